// File: doc/BRIEF.md
# I2C Clock and Data Timing Sequencer

This block generates the serial clock for an I2C controller and times every SDA transition against it. A bit-level sequencer asks it for one operation at a time: a START on an idle bus, a data bit, a repeated START, or a STOP. The block carries the operation out on open-drain drive outputs (a 1 on a drive output pulls the line low) and reports completion with a one-cycle done pulse. It also pulses a strobe when it changes SDA and a strobe when it samples SDA.

Four cycle counts shape the waveform. The bit period is the total of the low and high phases. The low count sets the low phase and the high phase takes the rest of the period. The condition count is used both as the hold time after a START and as the setup time before a repeated START or a STOP. The data setup count says how many cycles before SCL is released SDA takes its new value. Counts that would break the waveform are replaced with safe values. All counts are captured when an operation is accepted. The high phase is counted only once the SCL line reads high, so a target that stretches the clock simply lengthens that phase. After a STOP the bus stays free for one low-count before the block accepts another START.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset both drive outputs are 0 (lines released), `req_ready_o` is 1, and `bit_done_o`, `sda_chg_o`, `sda_smp_o` and `rx_bit_o` are 0.
- R2: A START (kind code 0) is accepted only on an idle bus. SDA is pulled low in the first cycle after acceptance. SCL stays released for C cycles, and then SCL is pulled low together with a done pulse.
- R3: A data bit (kind 1), a repeated START (kind 2) and a STOP (kind 3) are accepted only while SCL is parked low after an earlier operation. Each begins with exactly L cycles of SCL held low.
- R4: In that low phase SDA takes its new value exactly D cycles before SCL is released, and `sda_chg_o` pulses in the first cycle of the new value. The new value is not-`req_bit_i` on the low-drive output for a data bit, released for a repeated START, and low for a STOP.
- R5: After SCL is released, the high phase of a data bit lasts H = P - L cycles, counted from the first cycle in which `scl_in_i` reads high. A target holding SCL low delays the count. SDA does not change during the high phase.
- R6: At the end of a data bit's high phase, SCL is pulled low, `sda_smp_o` and `bit_done_o` pulse together, and `rx_bit_o` takes the value `sda_in_i` had in the last high cycle.
- R7: A repeated START holds SDA released with SCL high for C cycles, then SDA low with SCL high for C cycles, and then pulls SCL low with a done pulse.
- R8: A STOP holds SDA low with SCL high for C cycles and then releases SDA. Both lines then stay released for L cycles with `req_ready_o` at 0, after which a done pulse marks the idle bus.
- R9: The effective counts are: P is 4 when the period count is below 4, else the period count. L is P/2 when the low count is below 2 or not below P, else the low count. C is 1 when the condition count is 0, else the condition count. D is 1 when the data setup count is 0, L-1 when it is not below L, else the data setup count.
- R10: A request whose kind does not suit the bus state (a START while SCL is parked, or any other kind on an idle bus) is ignored, and the outputs are unchanged.
- R11: Changing the configuration counts while an operation runs has no effect on that operation.
- R12: `bit_done_o` is a one-cycle pulse. `req_ready_o` is 1 only while the bus is idle or SCL is parked low, and never while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period_i | input | CNT_W | Bit period in clock cycles |
| cfg_low_i | input | CNT_W | SCL low phase in clock cycles |
| cfg_cond_i | input | CNT_W | START hold / restart and STOP setup in clock cycles |
| cfg_dsetup_i | input | CNT_W | SDA-to-SCL-rise setup in clock cycles |
| req_valid_i | input | 1 | Operation request |
| req_kind_i | input | 2 | 0 START, 1 data bit, 2 repeated START, 3 STOP |
| req_bit_i | input | 1 | Bit value to send (1 releases SDA) |
| req_ready_o | output | 1 | Block can accept a suitable request |
| scl_in_i | input | 1 | Sampled SCL line level |
| sda_in_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| sda_chg_o | output | 1 | Pulse: SDA took its value for the coming bit |
| sda_smp_o | output | 1 | Pulse: SDA sampled into rx_bit_o |
| rx_bit_o | output | 1 | Last sampled SDA level |
| bit_done_o | output | 1 | Pulse: operation finished |

## Verification
The reference model is run with the typical ratio settings (low 11 of 20, condition 10, setup 1). These separate the low and high phases and show that the data setup point is taken from SCL release and not from the SCL fall. Degenerate counts (period 2, zeros) and an oversized low and data setup count check each clamp rule separately. A data bit sent while the target holds SCL low shows that the high phase waits for the line. Read bits with the target pulling SDA show that sampling takes the line and not the block's own drive. Sequences of repeated START and STOP, a START requested during the bus-free window, mismatched kinds, and a configuration change in mid-operation cover acceptance and capture of the counts.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    // Operation codes presented by the bit sequencer.
    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_BIT     = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } op_e;

    // Waveform phases of the timing engine.
    typedef enum logic [2:0] {
        PH_IDLE,   // bus free, both lines released
        PH_PARK,   // SCL held low between operations
        PH_LOW,    // programmed low phase of a clocked operation
        PH_WAIT,   // SCL released, waiting for the line to read high
        PH_HIGH,   // high phase of a data bit
        PH_CSU,    // condition setup with SCL high
        PH_CHD,    // condition hold with SCL high and SDA low
        PH_FREE    // bus-free time after STOP
    } phase_e;

    typedef struct packed {
        op_e  kind;
        logic bit_val;
    } req_t;

    localparam int unsigned MIN_LOW = 2;

    // SDA drive level taken during the low phase of a clocked operation.
    function automatic logic low_phase_sda(op_e kind, logic bit_val);
        case (kind)
            OP_BIT:  return ~bit_val;
            OP_STOP: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2ct_cfg_clamp.sv
module i2ct_cfg_clamp #(
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned MIN_PERIOD = 4
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] cond_i,
    input  logic [CNT_W-1:0] dsetup_i,
    output logic [CNT_W-1:0] low_o,
    output logic [CNT_W-1:0] high_o,
    output logic [CNT_W-1:0] cond_o,
    output logic [CNT_W-1:0] dsetup_o
);
    import i2ct_pkg::*;

    localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] LMIN = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] per_eff;

    always_comb begin
        per_eff  = (period_i < PMIN) ? PMIN : period_i;
        low_o    = (low_i < LMIN || low_i >= per_eff) ? (per_eff >> 1) : low_i;
        high_o   = per_eff - low_o;
        cond_o   = (cond_i == '0) ? ONE : cond_i;
        if (dsetup_i == '0)
            dsetup_o = ONE;
        else if (dsetup_i >= low_o)
            dsetup_o = low_o - ONE;
        else
            dsetup_o = dsetup_i;
    end

    always_comb begin
        if (!$isunknown({period_i, low_i, cond_i, dsetup_i})) begin
            AST_HIGH_NONZERO: assert (high_o != '0); // R9
            AST_SETUP_FITS_LOW: assert (dsetup_o != '0 && dsetup_o < low_o); // R9
        end
    end

endmodule

// File: rtl/i2ct_phase_cnt.sv
module i2ct_phase_cnt #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (load_i)
            cnt_o <= load_val_i;
        else if (cnt_o != '0)
            cnt_o <= cnt_o - CNT_W'(1);
    end

    assign zero_o = (cnt_o == '0);

    AST_CNT_PARKS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!load_i && zero_o) |=> zero_o); // R3

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned MIN_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_period_i,
    input  logic [CNT_W-1:0] cfg_low_i,
    input  logic [CNT_W-1:0] cfg_cond_i,
    input  logic [CNT_W-1:0] cfg_dsetup_i,
    input  logic             req_valid_i,
    input  logic [1:0]       req_kind_i,
    input  logic             req_bit_i,
    output logic             req_ready_o,
    input  logic             scl_in_i,
    input  logic             sda_in_i,
    output logic             scl_low_o,
    output logic             sda_low_o,
    output logic             sda_chg_o,
    output logic             sda_smp_o,
    output logic             rx_bit_o,
    output logic             bit_done_o
);
    import i2ct_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Clamped counts from the live configuration.
    logic [CNT_W-1:0] low_c, high_c, cond_c, dsu_c;
    // Counts captured at acceptance.
    logic [CNT_W-1:0] low_q, high_q, cond_q, dsu_q;

    phase_e phase_q;
    req_t   op_q;
    req_t   req_in;
    logic   accept;
    logic   cnt_load;
    logic   [CNT_W-1:0] cnt_val, cnt;
    logic   cnt_zero;

    i2ct_cfg_clamp #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_clamp (
        .period_i (cfg_period_i),
        .low_i    (cfg_low_i),
        .cond_i   (cfg_cond_i),
        .dsetup_i (cfg_dsetup_i),
        .low_o    (low_c),
        .high_o   (high_c),
        .cond_o   (cond_c),
        .dsetup_o (dsu_c)
    );

    i2ct_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .cnt_o      (cnt),
        .zero_o     (cnt_zero)
    );

    assign req_in.kind    = op_e'(req_kind_i);
    assign req_in.bit_val = req_bit_i;
    assign req_ready_o    = (phase_q == PH_IDLE) || (phase_q == PH_PARK);
    assign accept = req_valid_i &&
        (((phase_q == PH_IDLE) && (req_in.kind == OP_START)) ||
         ((phase_q == PH_PARK) && (req_in.kind != OP_START)));

    // Counter reload at each phase entry.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        case (phase_q)
            PH_IDLE: if (accept) begin
                cnt_load = 1'b1;
                cnt_val  = cond_c - ONE;
            end
            PH_PARK: if (accept) begin
                cnt_load = 1'b1;
                cnt_val  = low_c - ONE;
            end
            PH_WAIT: if (scl_in_i) begin
                cnt_load = 1'b1;
                cnt_val  = (op_q.kind == OP_BIT) ? high_q - ONE : cond_q - ONE;
            end
            PH_CSU: if (cnt_zero) begin
                cnt_load = 1'b1;
                cnt_val  = (op_q.kind == OP_RESTART) ? cond_q - ONE : low_q - ONE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            op_q       <= '{kind: OP_START, bit_val: 1'b0};
            low_q      <= '0;
            high_q     <= '0;
            cond_q     <= '0;
            dsu_q      <= '0;
            scl_low_o  <= 1'b0;
            sda_low_o  <= 1'b0;
            sda_chg_o  <= 1'b0;
            sda_smp_o  <= 1'b0;
            rx_bit_o   <= 1'b0;
            bit_done_o <= 1'b0;
        end else begin
            sda_chg_o  <= 1'b0;
            sda_smp_o  <= 1'b0;
            bit_done_o <= 1'b0;
            if (accept) begin
                low_q  <= low_c;
                high_q <= high_c;
                cond_q <= cond_c;
                dsu_q  <= dsu_c;
                op_q   <= req_in;
            end
            case (phase_q)
                PH_IDLE: if (accept) begin
                    sda_low_o <= 1'b1;
                    phase_q   <= PH_CHD;
                end
                PH_PARK: if (accept) phase_q <= PH_LOW;
                PH_LOW: begin
                    if (cnt == dsu_q) begin
                        sda_low_o <= low_phase_sda(op_q.kind, op_q.bit_val);
                        sda_chg_o <= 1'b1;
                    end
                    if (cnt_zero) begin
                        scl_low_o <= 1'b0;
                        phase_q   <= PH_WAIT;
                    end
                end
                PH_WAIT: if (scl_in_i)
                    phase_q <= (op_q.kind == OP_BIT) ? PH_HIGH : PH_CSU;
                PH_HIGH: if (cnt_zero) begin
                    scl_low_o  <= 1'b1;
                    bit_done_o <= 1'b1;
                    sda_smp_o  <= 1'b1;
                    rx_bit_o   <= sda_in_i;
                    phase_q    <= PH_PARK;
                end
                PH_CSU: if (cnt_zero) begin
                    if (op_q.kind == OP_RESTART) begin
                        sda_low_o <= 1'b1;
                        phase_q   <= PH_CHD;
                    end else begin
                        sda_low_o <= 1'b0;
                        phase_q   <= PH_FREE;
                    end
                end
                PH_CHD: if (cnt_zero) begin
                    scl_low_o  <= 1'b1;
                    bit_done_o <= 1'b1;
                    phase_q    <= PH_PARK;
                end
                PH_FREE: if (cnt_zero) begin
                    bit_done_o <= 1'b1;
                    phase_q    <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bit_done_o |=> !bit_done_o); // R12
    AST_LOW_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |-> scl_low_o); // R3
    AST_CHG_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        sda_chg_o |-> scl_low_o); // R4
    AST_SDA_STILL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH) |=> $stable(sda_low_o)); // R5
    AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_q == PH_HIGH) |-> $past(scl_in_i)); // R5
    AST_SMP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        sda_smp_o |-> (bit_done_o && scl_low_o)); // R6

endmodule

// File: tb/i2c_scl_timer_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb_top;

    localparam int CW = 10;

    typedef struct packed {
        bit scl; bit sda; bit chg; bit smp; bit done; bit rdy; bit wt;
    } ent_t;

    bit clk = 0;
    bit rst = 1;
    logic [CW-1:0] cfg_period = 20, cfg_low = 11, cfg_cond = 10, cfg_dsetup = 1;
    logic       req_valid = 0;
    logic [1:0] req_kind  = 0;
    logic       req_bit   = 0;
    bit stretch = 0;
    int stretch_left = 0;
    bit tgt_pull = 0;

    logic req_ready, scl_low, sda_low, sda_chg, sda_smp, rx_bit, bit_done;
    logic scl_in, sda_in;

    assign scl_in = !scl_low && !stretch;
    assign sda_in = !sda_low && !tgt_pull;

    always #2 clk = ~clk;   // 250 MHz

    i2c_scl_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_period_i(cfg_period), .cfg_low_i(cfg_low),
        .cfg_cond_i(cfg_cond), .cfg_dsetup_i(cfg_dsetup),
        .req_valid_i(req_valid), .req_kind_i(req_kind), .req_bit_i(req_bit),
        .req_ready_o(req_ready), .scl_in_i(scl_in), .sda_in_i(sda_in),
        .scl_low_o(scl_low), .sda_low_o(sda_low), .sda_chg_o(sda_chg),
        .sda_smp_o(sda_smp), .rx_bit_o(rx_bit), .bit_done_o(bit_done)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit chk_on = 0;
    bit acc = 0;
    bit exp_rx = 0;
    ent_t cur = '{scl: 0, sda: 0, chg: 0, smp: 0, done: 0, rdy: 1, wt: 0};
    ent_t q[$];

    function automatic void chk(bit act, bit exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
        end
    endfunction

    // Effective counts per R9.
    function automatic void eff(output int l, output int h, output int c, output int d);
        int p;
        p = (cfg_period < 4) ? 4 : int'(cfg_period);
        l = (cfg_low < 2 || int'(cfg_low) >= p) ? p / 2 : int'(cfg_low);
        h = p - l;
        c = (cfg_cond == 0) ? 1 : int'(cfg_cond);
        if (cfg_dsetup == 0) d = 1;
        else if (int'(cfg_dsetup) >= l) d = l - 1;
        else d = int'(cfg_dsetup);
    endfunction

    function automatic void push(bit scl, bit sda, bit chg, bit smp, bit done, bit rdy, bit wt);
        ent_t e;
        e = '{scl: scl, sda: sda, chg: chg, smp: smp, done: done, rdy: rdy, wt: wt};
        q.push_back(e);
    endfunction

    // Expected per-cycle waveform of one accepted operation.
    function automatic void build(int kind, bit b, bit s0);
        int l, h, c, d;
        bit ns;
        eff(l, h, c, d);
        if (kind == 0) begin                       // R2
            for (int i = 0; i < c; i++) push(0, 1, 0, 0, 0, 0, 0);
            push(1, 1, 0, 0, 1, 1, 0);
            return;
        end
        ns = (kind == 1) ? !b : (kind == 3);
        for (int i = 0; i < l; i++)                // R3, R4
            push(1, (i < l - d) ? s0 : ns, i == l - d, 0, 0, 0, 0);
        push(0, ns, 0, 0, 0, 0, 1);                // waits for the line (R5)
        if (kind == 1) begin
            for (int i = 0; i < h; i++) push(0, ns, 0, 0, 0, 0, 0);
            push(1, ns, 0, 1, 1, 1, 0);            // R6
        end else if (kind == 2) begin              // R7
            for (int i = 0; i < c; i++) push(0, 0, 0, 0, 0, 0, 0);
            for (int i = 0; i < c; i++) push(0, 1, 0, 0, 0, 0, 0);
            push(1, 1, 0, 0, 1, 1, 0);
        end else begin                             // R8
            for (int i = 0; i < c; i++) push(0, 1, 0, 0, 0, 0, 0);
            for (int i = 0; i < l; i++) push(0, 0, 0, 0, 0, 0, 0);
            push(0, 0, 0, 0, 1, 1, 0);
        end
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        ent_t prev;
        bit idle_s, park_s;
        cyc++;
        if (rst) begin
            cur = '{scl: 0, sda: 0, chg: 0, smp: 0, done: 0, rdy: 1, wt: 0};
            q.delete();
            exp_rx = 0;
            acc = 0;
        end else begin
            acc = 0;
            idle_s = (q.size() == 0) && !cur.wt && cur.rdy && !cur.scl;
            park_s = (q.size() == 0) && !cur.wt && cur.rdy && cur.scl;
            if (req_valid && ((idle_s && req_kind == 0) || (park_s && req_kind != 0))) begin
                acc = 1;
                build(int'(req_kind), req_bit, cur.sda);
            end
            if (cur.wt && stretch) begin
                // target still holds SCL low
            end else if (q.size() > 0) begin
                prev = cur;
                cur = q.pop_front();
                if (cur.smp) exp_rx = !prev.sda && !tgt_pull;
            end else begin
                cur.chg = 0; cur.smp = 0; cur.done = 0;
            end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R12 watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(scl_low,   cur.scl,  "R3 scl drive");
            chk(sda_low,   cur.sda,  "R4 sda drive");
            chk(sda_chg,   cur.chg,  "R4 sda change strobe");
            chk(sda_smp,   cur.smp,  "R6 sample strobe");
            chk(rx_bit,    exp_rx,   "R6 sampled bit");
            chk(bit_done,  cur.done, "R12 done pulse");
            chk(req_ready, cur.rdy,  "R12 ready");
        end
    end

    task automatic step();
        @(negedge clk);
        if (stretch_left > 0) stretch_left--;
        stretch = (stretch_left > 0);
    endtask

    task automatic start_op(int kind, bit b);
        req_kind  = 2'(kind);
        req_bit   = b;
        req_valid = 1;
        do step(); while (!acc);
        req_valid = 0;
    endtask

    task automatic wait_done();
        while (q.size() != 0) step();
        step();
    endtask

    task automatic do_op(int kind, bit b);
        start_op(kind, b);
        wait_done();
    endtask

    // One-cycle request that must be ignored (R10).
    task automatic poke(int kind);
        req_kind  = 2'(kind);
        req_bit   = 0;
        req_valid = 1;
        step();
        req_valid = 0;
        repeat (3) step();
    endtask

    initial begin
        repeat (4) step();
        rst = 0;
        step();
        chk_on = 1;
        // R1: released lines, ready, no pulses
        chk(scl_low, 0, "R1 reset scl");
        chk(sda_low, 0, "R1 reset sda");
        chk(req_ready, 1, "R1 reset ready");
        chk(bit_done, 0, "R1 reset done");

        poke(1);                  // R10: data bit on idle bus
        poke(3);                  // R10: STOP on idle bus
        do_op(0, 0);              // R2: START with typical ratios
        poke(0);                  // R10: START while parked
        tgt_pull = 1;
        do_op(1, 1);              // R6: read bit, target pulls SDA -> 0
        tgt_pull = 0;
        do_op(1, 1);              // R6: released bit -> 1
        do_op(1, 0);              // R4: driven zero
        stretch = 1; stretch_left = 20;
        do_op(1, 1);              // R5: target stretches SCL
        start_op(1, 0);           // R11: counts change mid-operation
        cfg_period = 8; cfg_low = 3; cfg_cond = 2; cfg_dsetup = 1;
        wait_done();
        cfg_period = 20; cfg_low = 11; cfg_cond = 10; cfg_dsetup = 1;
        do_op(2, 0);              // R7: repeated START
        do_op(1, 1);
        start_op(3, 0);           // R8: STOP, then START during bus-free time
        do_op(0, 0);
        do_op(3, 0);
        // R9: degenerate counts -> P4 L2 H2 C1 D1
        cfg_period = 2; cfg_low = 0; cfg_cond = 0; cfg_dsetup = 0;
        do_op(0, 0);
        do_op(1, 0);
        do_op(1, 1);
        do_op(3, 0);
        // R9: oversized low and setup -> P10 L5 H5 C3 D4
        cfg_period = 10; cfg_low = 12; cfg_cond = 3; cfg_dsetup = 9;
        do_op(0, 0);
        do_op(1, 0);
        do_op(2, 0);
        stretch = 1; stretch_left = 9;
        do_op(1, 1);
        do_op(3, 0);
        repeat (5) step();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule